// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit logical address into a physical address. It reads descriptors from a tree of tables in memory, one level at a time: first a root table, then a pointer table, then a page table. The pages are 8 KB. The supervisor flag of the request picks which of two root pointers starts the walk. A page-table entry may be an indirect descriptor. An indirect descriptor holds the address of a shared page descriptor, and the walker then reads that shared descriptor and uses it as the page descriptor. As a result, several logical pages can map to one frame and still keep one modified record.

Each table index is placed into a fixed bit slice of its level's base address. Every access goes through a single-word memory port with a valid/ready handshake, and only one access is outstanding at a time. For a write request, if the final descriptor does not yet have its modified bit set, the walker writes that descriptor back once with the bit set. At the end of a walk the block raises a one-cycle done pulse together with the physical address, or with a fault flag. It takes a new request only when it is idle.

Top module: `tlw_walker`

## Requirements
- R1: The first descriptor read of a walk uses `sup_root` when `req_super` is 1 and `usr_root` when `req_super` is 0.
- R2: The root descriptor address is root pointer bits 31..9, then logical bits 31..25 in bits 8..2, then two zero bits.
- R3: The pointer descriptor address is root descriptor bits 31..9, then logical bits 24..18 in bits 8..2, then two zero bits.
- R4: The page descriptor address is pointer descriptor bits 31..7, then logical bits 17..13 in bits 6..2, then two zero bits. For logical address 0x76543210 the three indices are 0x3B, 0x15 and 0x01.
- R5: The type of a descriptor is its bits 1..0: 00 is invalid, 01 is a valid table or a resident page, and 10 is indirect. Type 10 is legal only at the page level. Type 11 is illegal at every level. Type 10 at the root or pointer level is a fault.
- R6: When the page-level descriptor is indirect, the next read goes to that descriptor with bits 1..0 cleared, and the value read there is used as the page descriptor.
- R7: A walk faults on an invalid descriptor at any level or on an indirect descriptor that points to another indirect descriptor. It then ends with `fault`=1 and `paddr`=0, and makes no further memory access.
- R8: On success, `paddr` is bits 31..13 of the final descriptor joined with logical bits 12..0, and `fault`=0.
- R9: On a write request whose final descriptor has bit 4 (modified) clear, the walker writes that descriptor back once, with bit 4 set, to the address it was read from, before `done`. An indirect entry is never written.
- R10: There is no write-back when the request is a read or when bit 4 of the final descriptor is already set.
- R11: There is at most one memory access at a time. While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R12: `done` is high for exactly one cycle, the cycle after the last transfer of the walk. `req_valid` is ignored while a walk is in progress. When idle, the block makes no memory access.
- R13: After reset `mem_valid`, `done`, `fault` and `paddr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Starts a walk when the block is idle |
| req_laddr | input | 32 | Logical address to translate |
| req_super | input | 1 | 1 selects the supervisor root pointer |
| req_write | input | 1 | Access is a write (enables modified write-back) |
| sup_root | input | 32 | Supervisor root table pointer |
| usr_root | input | 32 | User root table pointer |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_addr | output | 32 | Word address of the descriptor |
| mem_we | output | 1 | 1 for the modified write-back |
| mem_wdata | output | 32 | Descriptor value for the write-back |
| mem_rdata | input | 32 | Read data, valid in the handshake cycle |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 1 | Walk ended on an illegal descriptor |
| paddr | output | 32 | Translated physical address |

## Verification
The assertions assume a memory that returns read data in the same cycle as the handshake and that raises `mem_ready` eventually. They also assume that the root pointers sampled when a request is accepted are the ones the walk is meant to use. The bench's memory drives `mem_rdata` combinationally from the presented address. The bench alternates between an always-ready memory and a memory that stalls two cycles out of three, so the hold rule is exercised. The bench raises a request only while the walker is idle, except for one deliberate window in which it holds a second request during a stalled walk to show that the second request is dropped.

// File: rtl/tlw_pkg.sv
// Shared types for the table walker: the walk state and the descriptor
// type code held in the two lowest bits of every descriptor.
package tlw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROOT,
        ST_PTR,
        ST_PAGE,
        ST_INDIR,
        ST_WBACK,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        DK_INVALID  = 2'b00,
        DK_VALID    = 2'b01,
        DK_INDIRECT = 2'b10,
        DK_RESERVED = 2'b11
    } desc_kind_e;

    // Descriptors are 32-bit words: table offsets skip two byte bits.
    localparam int unsigned WORD_LSB = 2;
endpackage

// File: rtl/tlw_desc_decode.sv
// Descriptor legality decode.
// Classifies the type bits of the word being read according to the level
// the walker is at. Assumes it is only consulted during a handshake cycle.
module tlw_desc_decode
    import tlw_pkg::*;
(
    input  logic [1:0]  type_bits,
    input  walk_state_e level,
    output logic        take_next,
    output logic        to_indir,
    output logic        bad
);
    desc_kind_e kind;

    assign kind = desc_kind_e'(type_bits);

    // Per-level acceptance: tables take only VALID, page level may go indirect.
    always_comb begin
        take_next = 1'b0;
        to_indir  = 1'b0;
        bad       = 1'b0;
        case (level)
            ST_ROOT, ST_PTR, ST_INDIR: begin
                take_next = (kind == DK_VALID);
                bad       = (kind != DK_VALID);
            end
            ST_PAGE: begin
                take_next = (kind == DK_VALID);
                to_indir  = (kind == DK_INDIRECT);
                bad       = (kind == DK_INVALID) || (kind == DK_RESERVED);
            end
            default: begin
                take_next = 1'b0;
                to_indir  = 1'b0;
                bad       = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/tlw_addr_mux.sv
// Descriptor address former.
// Places each level's index slice of the logical address into the fixed
// bit field of that level's base, or selects the indirect / write-back
// address. Assumes ROOT_IDX_W+PTR_IDX_W+PAGE_IDX_W+PAGE_OFS_W == AW.
module tlw_addr_mux
    import tlw_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter int unsigned ROOT_IDX_W = 7,
    parameter int unsigned PTR_IDX_W  = 7,
    parameter int unsigned PAGE_IDX_W = 5,
    parameter int unsigned PAGE_OFS_W = 13
) (
    input  walk_state_e   state,
    input  logic [AW-1:0] root_ptr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] laddr,
    input  logic [AW-1:0] fin_addr,
    output logic [AW-1:0] addr
);
    localparam int unsigned RT_LSB  = ROOT_IDX_W + WORD_LSB;
    localparam int unsigned PT_LSB  = PTR_IDX_W + WORD_LSB;
    localparam int unsigned PG_LSB  = PAGE_IDX_W + WORD_LSB;
    localparam int unsigned RI_LSB  = AW - ROOT_IDX_W;
    localparam int unsigned PI_LSB  = RI_LSB - PTR_IDX_W;
    localparam int unsigned PGI_LSB = PAGE_OFS_W;

    logic [AW-1:0] root_da, ptr_da, page_da, indir_da;
    logic          unused_bits;

    assign root_da  = {root_ptr[AW-1:RT_LSB], laddr[RI_LSB +: ROOT_IDX_W], {WORD_LSB{1'b0}}};
    assign ptr_da   = {base[AW-1:PT_LSB], laddr[PI_LSB +: PTR_IDX_W], {WORD_LSB{1'b0}}};
    assign page_da  = {base[AW-1:PG_LSB], laddr[PGI_LSB +: PAGE_IDX_W], {WORD_LSB{1'b0}}};
    assign indir_da = {base[AW-1:WORD_LSB], {WORD_LSB{1'b0}}};

    assign unused_bits = ^{root_ptr[RT_LSB-1:0], base[WORD_LSB-1:0], laddr[PGI_LSB-1:0]};

    // Select the address of the access belonging to the current state.
    always_comb begin
        case (state)
            ST_ROOT:  addr = root_da;
            ST_PTR:   addr = ptr_da;
            ST_PAGE:  addr = page_da;
            ST_INDIR: addr = indir_da;
            ST_WBACK: addr = fin_addr;
            default:  addr = '0;
        endcase
    end
endmodule

// File: rtl/tlw_ctrl.sv
// Walk sequencer.
// Holds the request, the last descriptor read and the final descriptor.
// It steps through root, pointer, page and optional indirect reads, adds
// a write-back when needed, and ends with a one-cycle DONE state.
// Assumes mem_rdata is valid in the cycle mem_valid && mem_ready.
module tlw_ctrl
    import tlw_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter int unsigned PAGE_OFS_W = 13,
    parameter int unsigned M_BIT      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_laddr,
    input  logic          req_super,
    input  logic          req_write,
    input  logic [AW-1:0] sup_root,
    input  logic [AW-1:0] usr_root,
    input  logic          mem_ready,
    input  logic [AW-1:0] mem_rdata,
    input  logic [AW-1:0] mem_addr,
    input  logic          take_next,
    input  logic          to_indir,
    input  logic          bad,
    output walk_state_e   state,
    output logic [AW-1:0] root_q,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] la_q,
    output logic [AW-1:0] fin_addr_q,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_wdata,
    output logic          done,
    output logic          fault,
    output logic [AW-1:0] paddr,
    output logic          walk_idle
);
    walk_state_e   state_q, state_d;
    logic [AW-1:0] la_d, root_d, base_d, fin_addr_d;
    logic [AW-1:0] fin_desc_q, fin_desc_d;
    logic [AW-1:0] paddr_q, paddr_d;
    logic          wr_q, wr_d, fault_q, fault_d;
    logic          xfer;

    assign xfer = mem_valid && mem_ready;

    // Next-state and datapath update for each step of the walk.
    always_comb begin
        state_d    = state_q;
        la_d       = la_q;
        root_d     = root_q;
        base_d     = base_q;
        fin_addr_d = fin_addr_q;
        fin_desc_d = fin_desc_q;
        paddr_d    = paddr_q;
        wr_d       = wr_q;
        fault_d    = fault_q;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_ROOT;
                    la_d    = req_laddr;
                    root_d  = req_super ? sup_root : usr_root;
                    wr_d    = req_write;
                    fault_d = 1'b0;
                    paddr_d = '0;
                end
            end
            ST_ROOT, ST_PTR: begin
                if (xfer) begin
                    if (bad) begin
                        fault_d = 1'b1;
                        paddr_d = '0;
                        state_d = ST_DONE;
                    end else begin
                        base_d  = mem_rdata;
                        state_d = (state_q == ST_ROOT) ? ST_PTR : ST_PAGE;
                    end
                end
            end
            ST_PAGE, ST_INDIR: begin
                if (xfer) begin
                    if (bad) begin
                        fault_d = 1'b1;
                        paddr_d = '0;
                        state_d = ST_DONE;
                    end else if (to_indir) begin
                        base_d  = mem_rdata;
                        state_d = ST_INDIR;
                    end else if (take_next) begin
                        fin_desc_d = mem_rdata;
                        fin_addr_d = mem_addr;
                        paddr_d    = {mem_rdata[AW-1:PAGE_OFS_W], la_q[PAGE_OFS_W-1:0]};
                        state_d    = (wr_q && !mem_rdata[M_BIT]) ? ST_WBACK : ST_DONE;
                    end
                end
            end
            ST_WBACK: begin
                if (xfer) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Walk registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            la_q       <= '0;
            root_q     <= '0;
            base_q     <= '0;
            fin_addr_q <= '0;
            fin_desc_q <= '0;
            paddr_q    <= '0;
            wr_q       <= 1'b0;
            fault_q    <= 1'b0;
        end else begin
            state_q    <= state_d;
            la_q       <= la_d;
            root_q     <= root_d;
            base_q     <= base_d;
            fin_addr_q <= fin_addr_d;
            fin_desc_q <= fin_desc_d;
            paddr_q    <= paddr_d;
            wr_q       <= wr_d;
            fault_q    <= fault_d;
        end
    end

    assign state     = state_q;
    assign mem_valid = (state_q == ST_ROOT) || (state_q == ST_PTR) || (state_q == ST_PAGE)
                    || (state_q == ST_INDIR) || (state_q == ST_WBACK);
    assign mem_we    = (state_q == ST_WBACK);
    assign mem_wdata = fin_desc_q | (AW'(1) << M_BIT);
    assign done      = (state_q == ST_DONE);
    assign fault     = fault_q;
    assign paddr     = paddr_q;
    assign walk_idle = (state_q == ST_IDLE);
endmodule

// File: rtl/tlw_walker.sv
// Three-level page table walker, top level.
// Connects the sequencer, the descriptor decode and the address former.
// Assumes one outstanding single-word memory access and 8 KB pages.
module tlw_walker
    import tlw_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter int unsigned ROOT_IDX_W = 7,
    parameter int unsigned PTR_IDX_W  = 7,
    parameter int unsigned PAGE_IDX_W = 5,
    parameter int unsigned PAGE_OFS_W = 13,
    parameter int unsigned M_BIT      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_laddr,
    input  logic          req_super,
    input  logic          req_write,
    input  logic [AW-1:0] sup_root,
    input  logic [AW-1:0] usr_root,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [AW-1:0] mem_wdata,
    input  logic [AW-1:0] mem_rdata,
    output logic          done,
    output logic          fault,
    output logic [AW-1:0] paddr
);
    walk_state_e   state;
    logic [AW-1:0] root_q, base_q, la_q, fin_addr_q;
    logic          take_next, to_indir, bad;
    logic          walk_idle;

    tlw_ctrl #(
        .AW(AW), .PAGE_OFS_W(PAGE_OFS_W), .M_BIT(M_BIT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_laddr(req_laddr),
        .req_super(req_super), .req_write(req_write),
        .sup_root(sup_root), .usr_root(usr_root),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .take_next(take_next), .to_indir(to_indir), .bad(bad),
        .state(state), .root_q(root_q), .base_q(base_q), .la_q(la_q),
        .fin_addr_q(fin_addr_q),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .done(done), .fault(fault), .paddr(paddr), .walk_idle(walk_idle)
    );

    tlw_desc_decode u_decode (
        .type_bits(mem_rdata[1:0]),
        .level(state),
        .take_next(take_next),
        .to_indir(to_indir),
        .bad(bad)
    );

    tlw_addr_mux #(
        .AW(AW), .ROOT_IDX_W(ROOT_IDX_W), .PTR_IDX_W(PTR_IDX_W),
        .PAGE_IDX_W(PAGE_IDX_W), .PAGE_OFS_W(PAGE_OFS_W)
    ) u_addr (
        .state(state), .root_ptr(root_q), .base(base_q), .laddr(la_q),
        .fin_addr(fin_addr_q), .addr(mem_addr)
    );
endmodule

// File: rtl/tlw_walker_chk.sv
// Property checker for the table walker, bound to the top level.
// Assumes mem_ready eventually follows mem_valid.
module tlw_walker_chk #(
    parameter int unsigned AW         = 32,
    parameter int unsigned ROOT_IDX_W = 7,
    parameter int unsigned M_BIT      = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] req_laddr,
    input logic          req_super,
    input logic [AW-1:0] sup_root,
    input logic [AW-1:0] usr_root,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic [AW-1:0] mem_wdata,
    input logic          done,
    input logic          fault,
    input logic [AW-1:0] paddr,
    input logic          walk_idle
);
    localparam int unsigned RT_LSB = ROOT_IDX_W + 2;

    logic unused_chk;
    assign unused_chk = ^{req_laddr[AW-ROOT_IDX_W-1:0], sup_root[RT_LSB-1:0], usr_root[RT_LSB-1:0]};

    AST_ROOT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_idle && req_valid) |=> (mem_valid && !mem_we &&
        mem_addr[AW-1:RT_LSB] == ($past(req_super) ? $past(sup_root[AW-1:RT_LSB])
                                                    : $past(usr_root[AW-1:RT_LSB])))); // R1
    AST_ROOT_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_idle && req_valid) |=>
        (mem_addr[RT_LSB-1:0] == {$past(req_laddr[AW-1 -: ROOT_IDX_W]), 2'b00})); // R2
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[1:0] == 2'b00)); // R6
    AST_FAULT_NO_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (paddr == '0)); // R7
    AST_WBACK_MOD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> mem_wdata[M_BIT]); // R9
    AST_HOLD_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=>
        (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_DONE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_valid); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        walk_idle |-> (!mem_valid && !done)); // R12
endmodule

bind tlw_walker tlw_walker_chk #(
    .AW(AW), .ROOT_IDX_W(ROOT_IDX_W), .M_BIT(M_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_laddr(req_laddr),
    .req_super(req_super), .sup_root(sup_root), .usr_root(usr_root),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .done(done), .fault(fault),
    .paddr(paddr), .walk_idle(walk_idle)
);

// File: tb/tlw_walker_test.sv
// Bench for the table walker: behavioural memory, per-walk expected access
// queue computed from the requirements, compared on every clock.
module tlw_walker_test;
    localparam logic [31:0] SRP = 32'h1000_0000;
    localparam logic [31:0] URP = 32'h2000_0200;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_super, req_write;
    logic [31:0] req_laddr;
    logic        mem_valid, mem_ready, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        done, fault;
    logic [31:0] paddr;

    logic [31:0] mem [0:1023];
    logic [31:0] q_addr [$];
    logic        q_we   [$];
    logic [31:0] q_wd   [$];
    logic [31:0] seen   [$];
    logic [31:0] exp_paddr;
    logic        exp_fault;
    bit          active, done_due, finished;
    int          stall_mode, cyc;
    int          n_checks, n_fail;
    string       cur_tag;

    always #10ns clk = ~clk;

    assign mem_rdata = mem[mem_addr[11:2]];

    tlw_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_laddr(req_laddr),
        .req_super(req_super), .req_write(req_write), .sup_root(SRP), .usr_root(URP),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .paddr(paddr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic void push(input logic [31:0] a, input logic w, input logic [31:0] d);
        q_addr.push_back(a);
        q_we.push_back(w);
        q_wd.push_back(d);
    endfunction

    // Expected access list and result, derived from R1..R10.
    function automatic void model(input logic [31:0] la, input bit sup, input bit wr);
        logic [31:0] r, a, d;
        q_addr.delete(); q_we.delete(); q_wd.delete();
        exp_fault = 1'b1;
        exp_paddr = 32'h0;
        r = sup ? SRP : URP;
        a = {r[31:9], la[31:25], 2'b00};
        push(a, 1'b0, 32'h0);
        d = mem[a[11:2]];
        if (d[1:0] != 2'b01) return;
        a = {d[31:9], la[24:18], 2'b00};
        push(a, 1'b0, 32'h0);
        d = mem[a[11:2]];
        if (d[1:0] != 2'b01) return;
        a = {d[31:7], la[17:13], 2'b00};
        push(a, 1'b0, 32'h0);
        d = mem[a[11:2]];
        if (d[1:0] == 2'b10) begin
            a = {d[31:2], 2'b00};
            push(a, 1'b0, 32'h0);
            d = mem[a[11:2]];
        end
        if (d[1:0] != 2'b01) return;
        exp_fault = 1'b0;
        exp_paddr = {d[31:13], la[12:0]};
        if (wr && !d[4]) push(a, 1'b1, d | 32'h10);
    endfunction

    // Per-clock comparison of the memory port and end of walk.
    always @(negedge clk) begin
        cyc++;
        mem_ready = (stall_mode == 0) || (cyc % 3 == 0);
        if (rst_n && active) begin
            if (done_due) begin
                check(done === 1'b1, "R12", "done after last transfer", 32'(done), 32'h1);
                check(fault === exp_fault, cur_tag, "fault", 32'(fault), 32'(exp_fault));
                check(paddr === exp_paddr, cur_tag, "paddr", paddr, exp_paddr);
                done_due = 1'b0;
                active   = 1'b0;
            end else begin
                check(mem_valid === (q_addr.size() != 0), "R11", "mem_valid",
                      32'(mem_valid), 32'(q_addr.size() != 0));
                check(done === 1'b0, "R12", "done early", 32'(done), 32'h0);
                if (mem_valid && mem_ready && q_addr.size() != 0) begin
                    check(mem_addr === q_addr[0], cur_tag, "access address", mem_addr, q_addr[0]);
                    check(mem_we === q_we[0], q_we[0] ? "R9" : "R10", "access write",
                          32'(mem_we), 32'(q_we[0]));
                    if (mem_we) begin
                        check(mem_wdata === q_wd[0], "R9", "write-back data", mem_wdata, q_wd[0]);
                        mem[mem_addr[11:2]] = mem_wdata;
                    end
                    seen.push_back(mem_addr);
                    void'(q_addr.pop_front());
                    void'(q_we.pop_front());
                    void'(q_wd.pop_front());
                    if (q_addr.size() == 0) done_due = 1'b1;
                end
            end
        end else if (rst_n) begin
            check(mem_valid === 1'b0 && done === 1'b0, "R12", "idle quiet",
                  {31'h0, mem_valid | done}, 32'h0);
        end
    end

    // One walk; optionally holds a second request during the busy window.
    task automatic run(input logic [31:0] la, input bit sup, input bit wr,
                       input string tag, input int busy_hold);
        model(la, sup, wr);
        cur_tag = tag;
        seen.delete();
        @(negedge clk);
        req_valid = 1'b1; req_laddr = la; req_super = sup; req_write = wr;
        @(posedge clk);
        active = 1'b1;
        @(negedge clk);
        if (busy_hold > 0) begin
            req_laddr = 32'h1234_5678; req_super = 1'b0; req_write = 1'b1;
            repeat (busy_hold) @(negedge clk);
        end
        req_valid = 1'b0;
        while (active) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %h expected %h", 32'h1, 32'h0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        rst_n = 1'b0; req_valid = 1'b0; req_laddr = '0; req_super = 1'b0; req_write = 1'b0;
        mem_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(mem_valid === 1'b0, "R13", "reset mem_valid", 32'(mem_valid), 32'h0);
        check(done === 1'b0 && fault === 1'b0, "R13", "reset done/fault",
              {30'h0, done, fault}, 32'h0);
        check(paddr === 32'h0, "R13", "reset paddr", paddr, 32'h0);

        // Supervisor tree for index 0x3B / 0x15 and user tree for 0x12345678.
        mem[32'h0EC >> 2] = 32'h3000_0401;
        mem[32'h454 >> 2] = 32'h4000_0801;
        mem[32'h804 >> 2] = 32'hABCD_E001;
        mem[32'h224 >> 2] = 32'h0000_0601;
        mem[32'h634 >> 2] = 32'h0000_0881;
        mem[32'h888 >> 2] = 32'h5555_A001;
        mem[32'h810 >> 2] = 32'h0000_0C02;
        mem[32'h814 >> 2] = 32'h0000_0C02;
        mem[32'hC00 >> 2] = 32'h7777_6001;
        mem[32'h818 >> 2] = 32'h0000_0C06;
        mem[32'hC04 >> 2] = 32'h0000_0C02;
        mem[32'h81C >> 2] = 32'h1234_5003;
        mem[32'h228 >> 2] = 32'h0000_0402;

        stall_mode = 0;
        run(32'h7654_3210, 1'b1, 1'b0, "R8", 0);
        check(seen.size() == 3, "R4", "access count", 32'(seen.size()), 32'h3);
        if (seen.size() == 3) begin
            check(seen[0][8:2] == 7'h3B, "R2", "root index", 32'(seen[0][8:2]), 32'h3B);
            check(seen[1][8:2] == 7'h15, "R3", "pointer index", 32'(seen[1][8:2]), 32'h15);
            check(seen[2][6:2] == 5'h01, "R4", "page index", 32'(seen[2][6:2]), 32'h01);
        end
        stall_mode = 1;
        run(32'h1234_5678, 1'b0, 1'b0, "R1", 0);     // user root, read: no write-back (R10)
        run(32'h1234_5678, 1'b0, 1'b1, "R9", 0);     // write with modified clear
        run(32'h1234_5678, 1'b0, 1'b1, "R10", 0);    // modified now set: no write-back
        stall_mode = 0;
        run(32'h1234_5678, 1'b1, 1'b0, "R7", 0);     // supervisor root entry invalid
        run(32'h7658_0000, 1'b1, 1'b0, "R7", 0);     // pointer entry invalid
        run(32'h7654_6000, 1'b1, 1'b0, "R7", 0);     // page entry invalid
        stall_mode = 1;
        run(32'h7654_8ABC, 1'b1, 1'b0, "R6", 0);     // indirect to shared descriptor
        stall_mode = 0;
        run(32'h7654_A123, 1'b1, 1'b1, "R9", 0);     // write through indirect
        check(mem[32'h814 >> 2] === 32'h0000_0C02, "R9", "indirect entry untouched",
              mem[32'h814 >> 2], 32'h0000_0C02);
        run(32'h7654_C000, 1'b1, 1'b0, "R7", 0);     // indirect chain
        run(32'h7654_E000, 1'b1, 1'b0, "R5", 0);     // type 11 at page level
        run(32'h1400_0000, 1'b0, 1'b0, "R5", 0);     // type 10 at root level
        stall_mode = 1;
        run(32'h7654_3210, 1'b1, 1'b0, "R12", 4);    // second request while busy ignored

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule